// File: doc/BRIEF.md
# ADC Result DMA Address Generator

This block sits between the conversion sequencer of a successive-approximation ADC and a DMA channel. Each finished conversion arrives on a valid/ready stream. The stream carries the analog input number, the sample/hold slot that produced the result, and a flag that marks the last conversion of a sequence. For each conversion the block accepts, it gives out one word address for the result and a one-cycle DMA request. The address and the request are registered together, so they are valid in the same cycle.

There are two fill modes. In conversion-order mode, results go to consecutive words of a 16-word window above a base address. This is the same placement as the converter's own result buffer. In scatter mode, each analog input owns a region of the DMA buffer sized by a power of two. A shared pointer picks the word inside the region. The pointer advances after a configurable number of completed sequences. The block also has a resolution mode. In high-resolution mode only one sample/hold channel converts, and every conversion is a sequence of its own. The block takes the resolution setting only while it is disabled.

Flow rules: the producer holds `conv_valid` and its fields until `conv_ready` is high. `conv_ready` follows `cfg_enable`, so nothing is taken while the block is off. The DMA side has no back-pressure: the engine must take one request per cycle.

Top module: `adc_dma_addr_gen`

## Requirements
- R1: `conv_ready` equals `cfg_enable`. A conversion is accepted in a cycle where both `conv_valid` and `conv_ready` are high.
- R2: A qualifying accepted conversion makes `dma_req` high for exactly the next cycle, with its address on `dma_addr` in that same cycle. `dma_req` is low in every other cycle.
- R3: With `cfg_fill_order`=1, the address is `cfg_base` + an order count. The count rises by one per qualifying conversion and wraps from 15 to 0.
- R4: With `cfg_fill_order`=0, the address is `cfg_base` + `conv_input`·2^`cfg_size_sel` + pointer. The address is taken modulo 2^16.
- R5: The pointer advances by one when a sequence ends and (`cfg_seq_per_step`+1) sequences have ended since the last advance. In normal mode a sequence ends on a qualifying conversion with `conv_last`=1. A conversion that ends a sequence still uses the pointer value from before the advance.
- R6: The pointer wraps to 0 when it would reach 2^`cfg_size_sel`.
- R7: In high-resolution mode, a conversion with `conv_slot`≠0 is ignored. Every qualifying conversion ends a sequence, whatever `conv_last` is.
- R8: A conversion with `conv_input` greater than 12 is ignored. It raises no request and changes no count.
- R9: The resolution mode takes the value of `cfg_hires` only in cycles where `cfg_enable` is low. Changes to `cfg_hires` while the block is enabled have no effect.
- R10: While `cfg_enable` is low, the pointer, the sequence count and the order count are held at zero and no request is raised. After reset `dma_req` and `dma_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_enable | input | 1 | Block enable; low clears all counts |
| cfg_fill_order | input | 1 | 1 = conversion-order fill, 0 = scatter fill |
| cfg_seq_per_step | input | 4 | Sequences per pointer advance, minus one |
| cfg_size_sel | input | 3 | Per-input region size is 2^value words |
| cfg_hires | input | 1 | Requested high-resolution (single sample/hold) mode |
| cfg_base | input | 16 | Base word address of the DMA buffer |
| conv_valid | input | 1 | Conversion result available |
| conv_ready | output | 1 | Block can accept a conversion |
| conv_input | input | 4 | Analog input number, 0 to 12 valid |
| conv_slot | input | 2 | Sample/hold slot that converted |
| conv_last | input | 1 | Last conversion of a sequence |
| dma_req | output | 1 | One-cycle DMA transfer request |
| dma_addr | output | 16 | Word address for the result |

## Verification
On every cycle, the assertions check these behaviours:
- a request never appears without an accepted conversion the cycle before;
- an out-of-range input, or an off-slot conversion in high-resolution mode, gives no request;
- the block stays quiet while disabled;
- the resolution mode stays fixed while the block is enabled;
- the pointer stays inside its region;
- order-mode addresses stay in the 16-word window.

The exact address values cannot be shown by a property; only the bench's reference model shows them. That covers when the pointer advances after the set number of sequences, its wrap, the order-count wrap, the clear on disable, and the late effect of a resolution change made while enabled.

// File: rtl/adg_pkg.sv
package adg_pkg;
  typedef enum logic {
    FILL_SCATTER = 1'b0,
    FILL_ORDER   = 1'b1
  } fill_mode_e;
endpackage

// File: rtl/adg_qualify.sv
// Decides whether an accepted conversion produces a transfer and whether it closes a sequence.
module adg_qualify #(
  parameter int IDX_W      = 4,
  parameter int SLOT_W     = 2,
  parameter int NUM_INPUTS = 13
) (
  input  logic              accept,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SLOT_W-1:0] slot,
  input  logic              last,
  input  logic              hires,
  output logic              qual,
  output logic              seq_end
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_INPUTS - 1);

  logic idx_ok;
  logic slot_ok;

  always_comb begin
    idx_ok  = (idx <= LAST_IDX);
    // single sample/hold in high-resolution mode: only slot 0 converts
    slot_ok = !hires || (slot == '0);
    qual    = accept && idx_ok && slot_ok;
    seq_end = qual && (hires || last);
  end
endmodule

// File: rtl/adg_counters.sv
// Sequence counter, scatter pointer and conversion-order count.
module adg_counters #(
  parameter int INCR_W     = 4,
  parameter int SIZE_SEL_W = 3,
  parameter int ORD_W      = 4,
  localparam int PTR_W     = (1 << SIZE_SEL_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  qual,
  input  logic                  seq_end,
  input  logic [INCR_W-1:0]     incr_sel,
  input  logic [SIZE_SEL_W-1:0] size_sel,
  output logic [PTR_W-1:0]      ptr,
  output logic [ORD_W-1:0]      ord
);
  logic [INCR_W-1:0] seq_q;
  logic [PTR_W:0]    size;
  logic [PTR_W:0]    ptr_next;

  always_comb begin
    size     = (PTR_W + 1)'(1) << size_sel;
    ptr_next = {1'b0, ptr} + (PTR_W + 1)'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q <= '0;
      ptr   <= '0;
    end else if (clear) begin
      seq_q <= '0;
      ptr   <= '0;
    end else if (seq_end) begin
      if (seq_q == incr_sel) begin
        seq_q <= '0;
        ptr   <= (ptr_next >= size) ? '0 : ptr_next[PTR_W-1:0];
      end else begin
        seq_q <= seq_q + INCR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ord <= '0;
    else if (clear)  ord <= '0;
    else if (qual)   ord <= ord + ORD_W'(1);
  end
endmodule

// File: rtl/adg_addr_calc.sv
// Combinational word address for both fill modes.
module adg_addr_calc #(
  parameter int ADDR_W     = 16,
  parameter int IDX_W      = 4,
  parameter int SIZE_SEL_W = 3,
  parameter int ORD_W      = 4,
  localparam int PTR_W     = (1 << SIZE_SEL_W) - 1
) (
  input  adg_pkg::fill_mode_e   mode,
  input  logic [ADDR_W-1:0]     base,
  input  logic [IDX_W-1:0]      idx,
  input  logic [SIZE_SEL_W-1:0] size_sel,
  input  logic [PTR_W-1:0]      ptr,
  input  logic [ORD_W-1:0]      ord,
  output logic [ADDR_W-1:0]     addr
);
  logic [ADDR_W-1:0] region;

  always_comb begin
    region = ADDR_W'(idx) << size_sel;
    if (mode == adg_pkg::FILL_ORDER) addr = base + ADDR_W'(ord);
    else                             addr = base + region + ADDR_W'(ptr);
  end
endmodule

// File: rtl/adc_dma_addr_gen.sv
module adc_dma_addr_gen #(
  parameter int ADDR_W       = 16,
  parameter int IDX_W        = 4,
  parameter int SLOT_W       = 2,
  parameter int NUM_INPUTS   = 13,
  parameter int INCR_W       = 4,
  parameter int SIZE_SEL_W   = 3,
  parameter int ORDER_DEPTH  = 16,
  localparam int ORD_W       = $clog2(ORDER_DEPTH),
  localparam int PTR_W       = (1 << SIZE_SEL_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_enable,
  input  logic                  cfg_fill_order,
  input  logic [INCR_W-1:0]     cfg_seq_per_step,
  input  logic [SIZE_SEL_W-1:0] cfg_size_sel,
  input  logic                  cfg_hires,
  input  logic [ADDR_W-1:0]     cfg_base,
  input  logic                  conv_valid,
  output logic                  conv_ready,
  input  logic [IDX_W-1:0]      conv_input,
  input  logic [SLOT_W-1:0]     conv_slot,
  input  logic                  conv_last,
  output logic                  dma_req,
  output logic [ADDR_W-1:0]     dma_addr
);
  logic                hires_q;
  logic                accept;
  logic                qual;
  logic                seq_end;
  logic [PTR_W-1:0]    ptr;
  logic [ORD_W-1:0]    ord;
  logic [ADDR_W-1:0]   addr_c;
  adg_pkg::fill_mode_e mode;

  assign conv_ready = cfg_enable;
  assign accept     = conv_valid && conv_ready;
  assign mode       = cfg_fill_order ? adg_pkg::FILL_ORDER : adg_pkg::FILL_SCATTER;

  // resolution mode is sampled only while the block is off
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           hires_q <= 1'b0;
    else if (!cfg_enable) hires_q <= cfg_hires;
  end

  adg_qualify #(
    .IDX_W(IDX_W), .SLOT_W(SLOT_W), .NUM_INPUTS(NUM_INPUTS)
  ) u_qual (
    .accept(accept), .idx(conv_input), .slot(conv_slot), .last(conv_last),
    .hires(hires_q), .qual(qual), .seq_end(seq_end)
  );

  adg_counters #(
    .INCR_W(INCR_W), .SIZE_SEL_W(SIZE_SEL_W), .ORD_W(ORD_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(!cfg_enable), .qual(qual),
    .seq_end(seq_end), .incr_sel(cfg_seq_per_step), .size_sel(cfg_size_sel),
    .ptr(ptr), .ord(ord)
  );

  adg_addr_calc #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_SEL_W(SIZE_SEL_W), .ORD_W(ORD_W)
  ) u_addr (
    .mode(mode), .base(cfg_base), .idx(conv_input), .size_sel(cfg_size_sel),
    .ptr(ptr), .ord(ord), .addr(addr_c)
  );

  // address and request leave through one register stage together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req  <= 1'b0;
      dma_addr <= '0;
    end else begin
      dma_req <= qual;
      if (qual) dma_addr <= addr_c;
    end
  end
endmodule

// File: rtl/adg_checker.sv
module adg_checker #(
  parameter int ADDR_W      = 16,
  parameter int IDX_W       = 4,
  parameter int SLOT_W      = 2,
  parameter int NUM_INPUTS  = 13,
  parameter int SIZE_SEL_W  = 3,
  parameter int ORDER_DEPTH = 16,
  localparam int PTR_W      = (1 << SIZE_SEL_W) - 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cfg_enable,
  input logic                  cfg_fill_order,
  input logic [SIZE_SEL_W-1:0] cfg_size_sel,
  input logic [ADDR_W-1:0]     cfg_base,
  input logic                  conv_valid,
  input logic                  conv_ready,
  input logic [IDX_W-1:0]      conv_input,
  input logic [SLOT_W-1:0]     conv_slot,
  input logic                  dma_req,
  input logic [ADDR_W-1:0]     dma_addr,
  input logic                  hires_q,
  input logic [PTR_W-1:0]      ptr
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_INPUTS - 1);

  a_r2_req_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> $past(conv_valid && conv_ready));

  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_enable) |-> !dma_req);

  a_r8_bad_input_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv_valid && (conv_input > LAST_IDX)) |-> !dma_req);

  a_r7_hires_slot_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    $past(conv_valid && hires_q && (conv_slot != '0)) |-> !dma_req);

  a_r9_hires_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_enable) |-> $stable(hires_q));

  a_r6_ptr_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_enable |-> ({1'b0, ptr} < ((PTR_W + 1)'(1) << cfg_size_sel)));

  a_r3_order_window: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && $past(cfg_fill_order))
      |-> ((dma_addr - $past(cfg_base)) < ADDR_W'(ORDER_DEPTH)));
endmodule

bind adc_dma_addr_gen adg_checker #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT_W(SLOT_W), .NUM_INPUTS(NUM_INPUTS),
  .SIZE_SEL_W(SIZE_SEL_W), .ORDER_DEPTH(ORDER_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
  .cfg_fill_order(cfg_fill_order), .cfg_size_sel(cfg_size_sel),
  .cfg_base(cfg_base), .conv_valid(conv_valid), .conv_ready(conv_ready),
  .conv_input(conv_input), .conv_slot(conv_slot), .dma_req(dma_req),
  .dma_addr(dma_addr), .hires_q(hires_q), .ptr(ptr)
);

// File: tb/sim_adc_dma_addr_gen.sv
`timescale 1ns/1ps
module sim_adc_dma_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0;
  logic        cfg_fill_order = 1'b0;
  logic [3:0]  cfg_seq_per_step = '0;
  logic [2:0]  cfg_size_sel = '0;
  logic        cfg_hires = 1'b0;
  logic [15:0] cfg_base = '0;
  logic        conv_valid = 1'b0;
  logic        conv_ready;
  logic [3:0]  conv_input = '0;
  logic [1:0]  conv_slot = '0;
  logic        conv_last = 1'b0;
  logic        dma_req;
  logic [15:0] dma_addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int m_seq = 0, m_ptr = 0, m_ord = 0;
  bit m_hires = 0;

  always #4 clk = ~clk;

  adc_dma_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_fill_order(cfg_fill_order), .cfg_seq_per_step(cfg_seq_per_step),
    .cfg_size_sel(cfg_size_sel), .cfg_hires(cfg_hires), .cfg_base(cfg_base),
    .conv_valid(conv_valid), .conv_ready(conv_ready), .conv_input(conv_input),
    .conv_slot(conv_slot), .conv_last(conv_last), .dma_req(dma_req),
    .dma_addr(dma_addr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit qualifies(bit v, int idx, int slot);
    return v && cfg_enable && (idx <= 12) && (!m_hires || slot == 0);
  endfunction

  function automatic int exp_addr(int idx);
    if (cfg_fill_order) return (int'(cfg_base) + m_ord) & 16'hffff;
    return (int'(cfg_base) + (idx << cfg_size_sel) + m_ptr) & 16'hffff;
  endfunction

  // one cycle: drive at negedge, check the registered result at the next negedge
  task automatic step(bit v, int idx, int slot, bit last, string tag);
    bit q;
    int ea;
    string rq;
    conv_valid = v; conv_input = 4'(idx); conv_slot = 2'(slot); conv_last = last;
    #1;
    chk("R1", int'(conv_ready), int'(cfg_enable));
    q  = qualifies(v, idx, slot);
    ea = exp_addr(idx);
    if (!cfg_enable) rq = "R10";
    else if (v && idx > 12) rq = "R8";
    else if (v && m_hires && slot != 0) rq = "R7";
    else rq = "R2";
    @(posedge clk);
    @(negedge clk);
    chk(rq, int'(dma_req), int'(q));
    if (q) chk(tag, int'(dma_addr), ea);
    if (q) begin
      m_ord = (m_ord + 1) % 16;
      if (m_hires || last) begin
        if (m_seq == int'(cfg_seq_per_step)) begin
          m_seq = 0;
          m_ptr = (m_ptr + 1) % (1 << cfg_size_sel);
        end else m_seq++;
      end
    end
    if (!cfg_enable) begin
      m_seq = 0; m_ptr = 0; m_ord = 0; m_hires = cfg_hires;
    end
    conv_valid = 1'b0;
  endtask

  task automatic setcfg(bit ord, int incr, int sel, bit hires, int base);
    cfg_enable = 1'b0;
    cfg_fill_order = ord; cfg_seq_per_step = 4'(incr); cfg_size_sel = 3'(sel);
    cfg_hires = hires; cfg_base = 16'(base);
    step(0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, "R10");
    cfg_enable = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    chk("R10", int'(dma_req), 0);
    chk("R10", int'(dma_addr), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5/R6: region of 2 words, advance every 2 sequences
    setcfg(0, 1, 1, 0, 16'h0100);
    for (int i = 0; i < 6; i++) step(1, 3, i % 4, 1, (i >= 4) ? "R6" : "R5");
    // conversions without the sequence flag do not advance the pointer (R5)
    for (int i = 0; i < 3; i++) step(1, 5, 0, 0, "R5");

    // R3: order-count wrap after 16 results
    setcfg(1, 0, 2, 0, 16'h2000);
    for (int i = 0; i < 18; i++) step(1, i % 13, i % 4, i[0], "R3");

    // R8: input 13..15 dropped without touching the counts
    step(1, 13, 0, 1, "R8");
    step(1, 15, 0, 1, "R8");
    step(1, 2, 0, 1, "R8");

    // R7: high resolution, slot 1 dropped, every conversion closes a sequence
    setcfg(0, 0, 2, 1, 16'h0400);
    step(1, 0, 1, 1, "R7");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, "R7");

    // R9: clearing the mode bit while enabled has no effect
    cfg_hires = 1'b0;
    step(1, 2, 2, 1, "R9");
    step(1, 2, 0, 0, "R9");
    step(1, 2, 0, 0, "R9");
    // takes effect only after a disabled cycle
    setcfg(0, 0, 2, 0, 16'h0400);
    step(1, 2, 2, 0, "R9");
    step(1, 2, 2, 0, "R9");

    // R10: disabling mid-run drops requests and clears the counts
    setcfg(1, 0, 0, 0, 16'h0050);
    for (int i = 0; i < 5; i++) step(1, 4, 0, 1, "R3");
    cfg_enable = 1'b0;
    step(1, 4, 0, 1, "R10");
    cfg_enable = 1'b1;
    step(1, 4, 0, 1, "R10");

    // random phases (R3, R4, R5, R6)
    for (int p = 0; p < 10; p++) begin
      setcfg(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(0, 7),
             1'($urandom_range(0, 1)), $urandom_range(0, 16'hffff));
      for (int n = 0; n < 80; n++)
        step($urandom_range(0, 3) != 0, $urandom_range(0, 14), $urandom_range(0, 3),
             1'($urandom_range(0, 1)), cfg_fill_order ? "R3" : "R4");
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule